// File: doc/BRIEF.md
# Multi-word adder with carry register

This execution unit serves add-with-carry instructions for long-integer arithmetic. Each accepted instruction adds two sub-words of `WORD_W` bits and returns their sum, registered, one cycle later. The carry-out is kept in a local flip-flop that persists between instructions. The next instruction can consume that carry without any branch in software.

A long addition is issued least significant word first. The first word uses the plain add opcode, which takes a carry-in of zero. Every later word uses the add-with-carry opcode, which takes the stored carry. After the last word, the stored carry is the top bit of the wide result and is readable on `carry_o`. A separate clear input zeroes the stored carry.

Top module: `mw_carry_adder`

## Requirements
- R1: While reset is asserted and after it is released, `sum_o` is 0, `sum_valid_o` is 0 and `carry_o` is 0.
- R2: An accepted instruction with `op_i` = 0 (plain add) produces `(a_i + b_i) mod 2^WORD_W` on `sum_o` after the next rising edge. The stored carry has no effect on this sum.
- R3: A plain add with `carry_clr_i` low stores its carry-out, bit `WORD_W` of `a_i + b_i`. The stored value appears on `carry_o` after the same edge.
- R4: An accepted instruction with `op_i` = 1 (add with carry) produces `(a_i + b_i + carry_o) mod 2^WORD_W` on `sum_o` after the next edge. `carry_o` here is the value held before that edge.
- R5: An add with carry, with `carry_clr_i` low, stores its own carry-out. The chained sequence of one plain add followed by adds with carry therefore yields the exact wide sum, with the final carry on `carry_o`. This holds for operands of 192 to 8192 bits.
- R6: `sum_valid_o` is high in exactly the cycle after an edge at which `valid_i` was high, and low otherwise.
- R7: At an edge where `valid_i` and `carry_clr_i` are both low, `sum_o` and `carry_o` keep their values, whatever `a_i`, `b_i` and `op_i` carry.
- R8: At an edge where `carry_clr_i` is high, the stored carry becomes 0, even if an instruction is accepted at that edge. Such an instruction still computes its sum with the carry held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction accepted at this edge |
| op_i | input | 1 | 0 = plain add, 1 = add with stored carry |
| a_i | input | WORD_W | First sub-word operand |
| b_i | input | WORD_W | Second sub-word operand |
| carry_clr_i | input | 1 | Force stored carry to 0 (wins over update) |
| sum_o | output | WORD_W | Registered sum |
| sum_valid_o | output | 1 | Sum updated by the previous edge |
| carry_o | output | 1 | Stored carry flip-flop |

## Verification
A corrupted carry flip-flop is visible on `carry_o` right after the faulty edge. The next add with carry then shows it as a sum that is off by one, one cycle later. A carry that leaks into a plain add shows up as a wrong low word at the start of a long addition. A lost clear priority leaves `carry_o` high after a clear edge. The word-by-word comparison against a wide reference sum places the first wrong bit within a single sub-word and a single cycle.

// File: rtl/mwadd_pkg.sv
package mwadd_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_ADC = 1'b1
  } op_e;
endpackage

// File: rtl/mwadd_sum_core.sv
module mwadd_sum_core #(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned SLICE_W = 16
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              cin_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int unsigned NSLICE = WORD_W / SLICE_W;

  logic [NSLICE:0] c;
  assign c[0] = cin_i;

  // ripple of slice adders
  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    logic [SLICE_W:0] part;
    assign part = {1'b0, a_i[g*SLICE_W +: SLICE_W]}
                + {1'b0, b_i[g*SLICE_W +: SLICE_W]}
                + {{SLICE_W{1'b0}}, c[g]};
    assign sum_o[g*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
    assign c[g+1] = part[SLICE_W];
  end

  assign cout_o = c[NSLICE];

  initial begin
    assert_slice_div: assert (NSLICE * SLICE_W == WORD_W);
  end
endmodule

// File: rtl/mwadd_carry_reg.sv
module mwadd_carry_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;
    else if (upd_i)  q_o <= d_i;
  end

  assert_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);
endmodule

// File: rtl/mwadd_out_reg.sv
module mwadd_out_reg #(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o,
  output logic              vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= en_i;
      if (en_i) q_o <= d_i;
    end
  end

  assert_vld_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> vld_o);
  assert_vld_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !vld_o);
endmodule

// File: rtl/mw_carry_adder.sv
module mw_carry_adder
  import mwadd_pkg::*;
#(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned SLICE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              carry_clr_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              sum_valid_o,
  output logic              carry_o
);
  op_e              op;
  logic             cin;
  logic             cout;
  logic [WORD_W-1:0] sum_d;

  assign op  = op_e'(op_i);
  assign cin = (op == OP_ADC) ? carry_o : 1'b0;

  mwadd_sum_core #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) i_core (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin),
    .sum_o (sum_d),
    .cout_o(cout)
  );

  mwadd_carry_reg i_carry (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (carry_clr_i),
    .upd_i (valid_i),
    .d_i   (cout),
    .q_o   (carry_o)
  );

  mwadd_out_reg #(.WORD_W(WORD_W)) i_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .d_i   (sum_d),
    .q_o   (sum_o),
    .vld_o (sum_valid_o)
  );

  assert_add_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i) |=> sum_o == $past(a_i) + $past(b_i));

  // carry out of a+b exactly when a > ~b
  assert_add_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i && !carry_clr_i) |=> carry_o == ($past(a_i) > ~$past(b_i)));

  assert_adc_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i) |=>
      sum_o == $past(a_i) + $past(b_i) + {{(WORD_W-1){1'b0}}, $past(carry_o)});

  assert_adc_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i && !carry_clr_i) |=>
      carry_o == (($past(a_i) > ~$past(b_i)) ||
                  ($past(carry_o) && ($past(a_i) == ~$past(b_i)))));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !carry_clr_i) |=> ($stable(carry_o) && $stable(sum_o)));
endmodule

// File: tb/test_mw_carry_adder.sv
`timescale 1ns/1ps
module test_mw_carry_adder;
  localparam int unsigned W = 64;
  localparam int unsigned MAXB = 8192;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic         op = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         clr = 1'b0;
  logic [W-1:0] sum;
  logic         sum_vld;
  logic         carry;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [W-1:0] ONES = '1;

  always #2 clk = ~clk;

  mw_carry_adder #(.WORD_W(W)) i_mw_carry_adder (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .a_i(a), .b_i(b), .carry_clr_i(clr),
    .sum_o(sum), .sum_valid_o(sum_vld), .carry_o(carry)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the capturing edge
  task automatic issue(input logic o, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic c);
    @(negedge clk);
    valid = 1'b1; op = o; a = x; b = y; clr = c;
    @(posedge clk); #1;
    valid = 1'b0; clr = 1'b0;
  endtask

  task automatic set_carry();
    issue(1'b0, ONES, 64'd1, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 sum", sum, '0);
    chk("R1 valid", W'(sum_vld), '0);
    chk("R1 carry", W'(carry), '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 carry after release", W'(carry), '0);
    chk("R1 valid after release", W'(sum_vld), '0);
  endtask

  task automatic t_add();
    issue(1'b0, 64'd5, 64'd7, 1'b0);
    chk("R2 5+7", sum, 64'd12);
    chk("R3 carry 0", W'(carry), 64'd0);
    chk("R6 valid", W'(sum_vld), 64'd1);
    issue(1'b0, ONES, 64'd1, 1'b0);
    chk("R2 wrap", sum, 64'd0);
    chk("R3 carry 1", W'(carry), 64'd1);
    issue(1'b0, 64'd3, 64'd4, 1'b0); // stored carry 1 ignored
    chk("R2 ignores carry", sum, 64'd7);
    chk("R3 carry cleared by add", W'(carry), 64'd0);
  endtask

  task automatic t_adc();
    set_carry();
    issue(1'b1, 64'd10, 64'd20, 1'b0);
    chk("R4 10+20+1", sum, 64'd31);
    chk("R5 carry 0", W'(carry), 64'd0);
    issue(1'b1, ONES, 64'd0, 1'b0);
    chk("R4 ones+0+0", sum, ONES);
    chk("R5 no carry", W'(carry), 64'd0);
    set_carry();
    issue(1'b1, ONES, 64'd0, 1'b0);
    chk("R4 ones+0+1", sum, 64'd0);
    chk("R5 carry ripple", W'(carry), 64'd1);
    issue(1'b1, ONES, ONES, 1'b0);
    chk("R4 ones+ones+1", sum, ONES);
    chk("R5 carry kept", W'(carry), 64'd1);
  endtask

  task automatic t_idle();
    logic [W-1:0] s0;
    logic c0;
    set_carry();
    s0 = sum; c0 = carry;
    @(negedge clk);
    valid = 1'b0; op = 1'b1; a = 64'h1234; b = ONES;
    @(posedge clk); #1;
    chk("R6 valid low", W'(sum_vld), 64'd0);
    chk("R7 sum held", sum, s0);
    chk("R7 carry held", W'(carry), W'(c0));
  endtask

  task automatic t_clear();
    set_carry();
    @(negedge clk); clr = 1'b1;
    @(posedge clk); #1; clr = 1'b0;
    chk("R8 clear alone", W'(carry), 64'd0);
    set_carry();
    issue(1'b1, 64'd1, ONES, 1'b1);
    chk("R8 sum uses old carry", sum, 64'd1);
    chk("R8 clear wins", W'(carry), 64'd0);
    issue(1'b0, ONES, 64'd1, 1'b1);
    chk("R8 clear over add", W'(carry), 64'd0);
  endtask

  task automatic t_long(input int nbits);
    logic [MAXB-1:0] x, y;
    logic [MAXB:0]   r;
    int nw;
    nw = nbits / W;
    x = '0; y = '0;
    for (int i = 0; i < nbits / 32; i++) begin
      x[i*32 +: 32] = $urandom;
      y[i*32 +: 32] = $urandom;
    end
    r = {1'b0, x} + {1'b0, y};
    set_carry(); // leftover carry must not leak into word 0
    for (int i = 0; i < nw; i++) begin
      issue(i == 0 ? 1'b0 : 1'b1, x[i*W +: W], y[i*W +: W], 1'b0);
      chk($sformatf("R5 %0d-bit word %0d", nbits, i), sum, r[i*W +: W]);
    end
    chk($sformatf("R5 %0d-bit final carry", nbits), W'(carry), W'(r[nbits]));
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    t_add();
    t_adc();
    t_idle();
    t_clear();
    t_long(192);
    t_long(1024);
    t_long(2048);
    t_long(4096);
    t_long(8192);
    // all-ones + 1 across full width
    begin
      set_carry();
      for (int i = 0; i < 16; i++) begin
        issue(i == 0 ? 1'b0 : 1'b1, ONES, i == 0 ? 64'd1 : 64'd0, 1'b0);
        chk("R5 full ripple word", sum, 64'd0);
      end
      chk("R5 full ripple carry", W'(carry), 64'd1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule